// File: doc/BRIEF.md
# Floppy Controller Phase Sequencer

This block is the host-side protocol engine of a floppy disk controller. A host reaches it through one byte-wide data register and a main status word that carries four flags: request-for-master (RQM), data direction (DIO, high when the host should read), controller busy and non-DMA. The engine cycles through three phases. In the command phase the host writes an opcode byte followed by the parameter bytes that the opcode needs. In a short execution step the engine builds the result bytes in its internal buffer. In the result phase the host reads those bytes back, and after the last one the engine is ready for a new command.

The command set is small: version, part identification, configure, specify, sense interrupt and dump registers. Every other opcode is rejected with a one-byte error result. A drive-side event input stands in for seek completion. It latches a status byte and a track number and raises the interrupt line, and the sense interrupt command reports and clears that interrupt. Command bytes and result bytes share one sector-sized byte buffer. The buffer is addressed by the running byte position modulo its depth.

Top module: `fdc_phase_seq`

## Requirements
- R1: After reset, rqm is 1 and dio, busy, irq and proto_err are 0.
- R2: While the engine waits for an opcode (busy 0), rqm is 1 and dio is 0.
- R3: Writing the opcode of a command that takes parameters sets busy and leaves rqm at 1 and dio at 0. Configure (0x13) takes 3 parameters, specify (0x03) takes 2, and all other opcodes take none.
- R4: In the cycle after the last command byte is written, rqm is 0 and busy is 1. rqm stays 0 until the result phase or the idle command phase is reached.
- R5: While result bytes wait to be read, rqm, dio and busy are all 1.
- R6: The read of the last result byte returns the engine to the command phase (rqm 1, dio 0, busy 0) and drops irq.
- R7: Any opcode other than 0x10, 0x18, 0x13, 0x03, 0x08 and 0x0E gives exactly one result byte, 0x80.
- R8: Part identification (0x18) gives the single byte 0x41. Version (0x10) gives the single byte VERSION_ID.
- R9: Configure and specify give no result bytes and go straight back to the command phase. Configure stores parameter 2 as the config byte and parameter 3 as the precompensation byte. Specify stores parameters 1 and 2.
- R10: A pulse on ev_pulse latches ev_status and ev_track and raises irq. Sense interrupt (0x08) then gives two bytes, the latched status and the track, and clears irq. With no pending interrupt it gives the single byte 0x80.
- R11: A data read in the command phase, or a data write in the result phase, changes neither the phase nor the flags, and it sets the sticky proto_err output.
- R12: Dump registers (0x0E) gives 10 bytes in this order: track, 0, 0, 0, specify byte 1, specify byte 2, 0, 0, config, precompensation. Byte n is stored and read at buffer index n modulo FIFO_DEPTH, so a later byte overwrites an earlier one that shares its index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Data register write strobe |
| wr_data | input | 8 | Byte written by the host |
| rd_en | input | 1 | Data register read strobe |
| rd_data | output | 8 | Byte read, valid the cycle after rd_en |
| ev_pulse | input | 1 | Drive event: latch status and track, raise irq |
| ev_status | input | 8 | Status byte reported by sense interrupt |
| ev_track | input | 8 | Current track reported by sense interrupt and dump |
| st_rqm | output | 1 | Ready for a host data transfer |
| st_dio | output | 1 | Direction: 1 means the host reads |
| st_busy | output | 1 | Command in progress |
| st_nondma | output | 1 | Non-DMA transfer flag (no such transfers here, held 0) |
| irq | output | 1 | Interrupt request |
| proto_err | output | 1 | Sticky flag for out-of-phase data access |

## Verification
The bench builds the engine with FIFO_DEPTH set to 8 and VERSION_ID set to 0x90. With a depth of 8, the ten-byte dump result wraps around the buffer. Bytes 8 and 9 then land on indexes 0 and 1, so the modulo addressing shows up directly in the bytes that are read back. All 256 opcode values are swept through the full command, execution and result sequence and compared against an arithmetic model of the parameter counts, the result bytes and the stored configuration. Drive events, a sense interrupt with an interrupt pending, and both kinds of out-of-phase access are then run separately.

// File: rtl/fdc_seq_pkg.sv
package fdc_seq_pkg;

  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_EXEC = 2'd1,
    PH_RES  = 2'd2
  } phase_t;

  localparam logic [7:0] OP_VERSION = 8'h10;
  localparam logic [7:0] OP_PARTID  = 8'h18;
  localparam logic [7:0] OP_CONFIG  = 8'h13;
  localparam logic [7:0] OP_SPECIFY = 8'h03;
  localparam logic [7:0] OP_SENSE   = 8'h08;
  localparam logic [7:0] OP_DUMP    = 8'h0E;

  localparam logic [7:0] BYTE_INVALID = 8'h80;
  localparam logic [7:0] BYTE_PARTID  = 8'h41;

  // Parameter bytes that follow each opcode
  function automatic logic [3:0] param_count(input logic [7:0] op);
    case (op)
      OP_CONFIG:  param_count = 4'd3;
      OP_SPECIFY: param_count = 4'd2;
      default:    param_count = 4'd0;
    endcase
  endfunction

endpackage

// File: rtl/fdc_fifo_ram.sv
module fdc_fifo_ram #(
  parameter int DEPTH = 512,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/fdc_result_gen.sv
module fdc_result_gen
  import fdc_seq_pkg::*;
#(
  parameter logic [7:0] VERSION_ID = 8'h90
) (
  input  logic [7:0] opcode,
  input  logic [3:0] idx,
  input  logic       pend,
  input  logic [7:0] st0,
  input  logic [7:0] trk,
  input  logic [7:0] spec_a,
  input  logic [7:0] spec_b,
  input  logic [7:0] cfg,
  input  logic [7:0] precomp,
  output logic [3:0] res_len,
  output logic [7:0] res_byte
);

  always_comb begin
    res_len  = 4'd1;
    res_byte = BYTE_INVALID;
    case (opcode)
      OP_VERSION: res_byte = VERSION_ID;
      OP_PARTID:  res_byte = BYTE_PARTID;
      OP_CONFIG, OP_SPECIFY: begin
        res_len  = 4'd0;
        res_byte = 8'h00;
      end
      OP_SENSE: begin
        if (pend) begin
          res_len  = 4'd2;
          res_byte = (idx == 4'd0) ? st0 : trk;
        end
      end
      OP_DUMP: begin
        res_len = 4'd10;
        case (idx)
          4'd0:    res_byte = trk;
          4'd4:    res_byte = spec_a;
          4'd5:    res_byte = spec_b;
          4'd8:    res_byte = cfg;
          4'd9:    res_byte = precomp;
          default: res_byte = 8'h00;
        endcase
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/fdc_phase_seq.sv
module fdc_phase_seq
  import fdc_seq_pkg::*;
#(
  parameter int         FIFO_DEPTH = 512,
  parameter logic [7:0] VERSION_ID = 8'h90
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  input  logic       ev_pulse,
  input  logic [7:0] ev_status,
  input  logic [7:0] ev_track,
  output logic       st_rqm,
  output logic       st_dio,
  output logic       st_busy,
  output logic       st_nondma,
  output logic       irq,
  output logic       proto_err
);

  localparam int AW = $clog2(FIFO_DEPTH);
  localparam int PW = AW + 4;

  phase_t        phase;
  logic [PW-1:0] pos, len, k;
  logic [PW-1:0] pos_nx;
  logic [7:0]    op_q;
  logic          pend_q;
  logic [7:0]    st0_q, trk_q, spec_a_q, spec_b_q, cfg_q, pre_q;
  logic [3:0]    pcnt;
  logic [3:0]    rlen;
  logic [7:0]    rbyte;
  logic          exec_more;

  logic          mem_we, mem_re;
  logic [AW-1:0] mem_waddr;
  logic [7:0]    mem_wdata;

  assign pos_nx    = pos + 1'b1;
  assign pcnt      = param_count(wr_data);
  assign exec_more = k < {{(PW-4){1'b0}}, rlen};
  assign st_nondma = 1'b0;

  fdc_result_gen #(.VERSION_ID(VERSION_ID)) gen_i (
    .opcode  (op_q),
    .idx     (k[3:0]),
    .pend    (pend_q),
    .st0     (st0_q),
    .trk     (trk_q),
    .spec_a  (spec_a_q),
    .spec_b  (spec_b_q),
    .cfg     (cfg_q),
    .precomp (pre_q),
    .res_len (rlen),
    .res_byte(rbyte)
  );

  always_comb begin
    mem_we    = 1'b0;
    mem_waddr = pos[AW-1:0];
    mem_wdata = wr_data;
    if (phase == PH_CMD && wr_en) begin
      mem_we = 1'b1;
    end else if (phase == PH_EXEC && exec_more) begin
      mem_we    = 1'b1;
      mem_waddr = k[AW-1:0];
      mem_wdata = rbyte;
    end
  end

  assign mem_re = (phase == PH_RES) && rd_en;

  fdc_fifo_ram #(.DEPTH(FIFO_DEPTH), .AW(AW)) ram_i (
    .clk  (clk),
    .we   (mem_we),
    .waddr(mem_waddr),
    .wdata(mem_wdata),
    .re   (mem_re),
    .raddr(pos[AW-1:0]),
    .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_CMD;
      pos       <= '0;
      len       <= PW'(1);
      k         <= '0;
      op_q      <= '0;
      pend_q    <= 1'b0;
      st_rqm    <= 1'b1;
      st_dio    <= 1'b0;
      st_busy   <= 1'b0;
      irq       <= 1'b0;
      proto_err <= 1'b0;
      st0_q     <= '0;
      trk_q     <= '0;
      spec_a_q  <= '0;
      spec_b_q  <= '0;
      cfg_q     <= '0;
      pre_q     <= '0;
    end else begin
      case (phase)
        PH_CMD: begin
          if (wr_en) begin
            pos     <= pos_nx;
            st_busy <= 1'b1;
            if (pos == '0) begin
              op_q <= wr_data;
              len  <= PW'(pcnt) + 1'b1;
              if (pcnt == 4'd0) begin
                st_rqm <= 1'b0;
                phase  <= PH_EXEC;
                k      <= '0;
                pend_q <= irq;
              end
            end else begin
              if (op_q == OP_CONFIG && pos == PW'(2)) cfg_q    <= wr_data;
              if (op_q == OP_CONFIG && pos == PW'(3)) pre_q    <= wr_data;
              if (op_q == OP_SPECIFY && pos == PW'(1)) spec_a_q <= wr_data;
              if (op_q == OP_SPECIFY && pos == PW'(2)) spec_b_q <= wr_data;
              if (pos_nx == len) begin
                st_rqm <= 1'b0;
                phase  <= PH_EXEC;
                k      <= '0;
                pend_q <= irq;
              end
            end
          end else if (rd_en) begin
            proto_err <= 1'b1;
          end
        end
        PH_EXEC: begin
          if (exec_more) begin
            k <= k + 1'b1;
          end else if (rlen == 4'd0) begin
            phase   <= PH_CMD;
            pos     <= '0;
            len     <= PW'(1);
            st_rqm  <= 1'b1;
            st_dio  <= 1'b0;
            st_busy <= 1'b0;
          end else begin
            phase   <= PH_RES;
            pos     <= '0;
            len     <= PW'(rlen);
            st_rqm  <= 1'b1;
            st_dio  <= 1'b1;
            st_busy <= 1'b1;
            if (op_q == OP_SENSE && pend_q) irq <= 1'b0;
          end
        end
        PH_RES: begin
          if (rd_en) begin
            pos <= pos_nx;
            if (pos_nx == len) begin
              phase   <= PH_CMD;
              pos     <= '0;
              len     <= PW'(1);
              st_rqm  <= 1'b1;
              st_dio  <= 1'b0;
              st_busy <= 1'b0;
              irq     <= 1'b0;
            end
          end else if (wr_en) begin
            proto_err <= 1'b1;
          end
        end
        default: phase <= PH_CMD;
      endcase
      if (ev_pulse) begin
        irq   <= 1'b1;
        st0_q <= ev_status;
        trk_q <= ev_track;
      end
    end
  end

endmodule

// File: rtl/fdc_phase_seq_chk.sv
module fdc_phase_seq_chk (
  input logic clk,
  input logic rst,
  input logic wr_en,
  input logic rd_en,
  input logic ev_pulse,
  input logic st_rqm,
  input logic st_dio,
  input logic st_busy,
  input logic irq,
  input logic proto_err
);

  AST_IDLE_READY: assert property (@(posedge clk) disable iff (rst)
    !st_busy |-> (st_rqm && !st_dio)); // R2

  AST_EXEC_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    $fell(st_rqm) |-> (st_busy && !st_dio)); // R4

  AST_RESULT_FLAGS: assert property (@(posedge clk) disable iff (rst)
    st_dio |-> (st_rqm && st_busy)); // R5

  AST_RESULT_DONE: assert property (@(posedge clk) disable iff (rst)
    ($fell(st_dio) && !$past(ev_pulse)) |-> (!irq && st_rqm && !st_busy)); // R6

  AST_WRITE_IN_RESULT: assert property (@(posedge clk) disable iff (rst)
    (st_dio && wr_en && !rd_en) |=> (st_dio && proto_err)); // R11

  AST_READ_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!st_busy && rd_en && !wr_en) |=> (!st_busy && proto_err)); // R11

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> proto_err); // R11

endmodule

bind fdc_phase_seq fdc_phase_seq_chk chk_i (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .ev_pulse (ev_pulse),
  .st_rqm   (st_rqm),
  .st_dio   (st_dio),
  .st_busy  (st_busy),
  .irq      (irq),
  .proto_err(proto_err)
);

// File: tb/fdc_phase_seq_tb.sv
`timescale 1ns/1ps
module fdc_phase_seq_tb_top;

  localparam int         DEPTH = 8;
  localparam logic [7:0] VER   = 8'h90;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0, ev_pulse = 1'b0;
  logic [7:0] wr_data = '0, ev_status = '0, ev_track = '0;
  logic [7:0] rd_data;
  logic       st_rqm, st_dio, st_busy, st_nondma, irq, proto_err;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  // model state
  logic [7:0] m_cfg = 0, m_pre = 0, m_sa = 0, m_sb = 0, m_st0 = 0, m_trk = 0;
  logic       m_irq = 0;

  always #2.5 clk = ~clk;

  fdc_phase_seq #(.FIFO_DEPTH(DEPTH), .VERSION_ID(VER)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .ev_pulse(ev_pulse), .ev_status(ev_status),
    .ev_track(ev_track), .st_rqm(st_rqm), .st_dio(st_dio), .st_busy(st_busy),
    .st_nondma(st_nondma), .irq(irq), .proto_err(proto_err)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int m_pcnt(input logic [7:0] op);
    if (op == 8'h13) return 3;
    if (op == 8'h03) return 2;
    return 0;
  endfunction

  function automatic logic [7:0] m_param(input logic [7:0] op, input int j);
    return op ^ 8'(j * 8'h35);
  endfunction

  function automatic int m_rlen(input logic [7:0] op);
    case (op)
      8'h13, 8'h03: return 0;
      8'h08: return m_irq ? 2 : 1;
      8'h0E: return 10;
      default: return 1;
    endcase
  endfunction

  function automatic logic [7:0] m_byte(input logic [7:0] op, input int i);
    case (op)
      8'h10: return VER;
      8'h18: return 8'h41;
      8'h08: return m_irq ? ((i == 0) ? m_st0 : m_trk) : 8'h80;
      8'h0E: case (i)
               0: return m_trk;
               4: return m_sa;
               5: return m_sb;
               8: return m_cfg;
               9: return m_pre;
               default: return 8'h00;
             endcase
      default: return 8'h80;
    endcase
  endfunction

  function automatic string m_tag(input logic [7:0] op);
    case (op)
      8'h10, 8'h18: return "R8";
      8'h13, 8'h03: return "R9";
      8'h08: return "R10";
      8'h0E: return "R12";
      default: return "R7";
    endcase
  endfunction

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic wait_rqm();
    for (int t = 0; t < 40 && !st_rqm; t++) @(negedge clk);
  endtask

  task automatic run_cmd(input logic [7:0] op);
    int pc, rn, j;
    logic [7:0] exp_b [16];
    logic [7:0] got;
    pc = m_pcnt(op);
    rn = m_rlen(op);
    for (int i = 0; i < rn; i++) exp_b[i] = m_byte(op, i);
    wr(op);
    if (pc > 0) begin
      chk("R3 busy", {7'd0, st_busy}, 8'd1);
      chk("R3 rqm/dio", {6'd0, st_rqm, st_dio}, 8'b10);
      for (int p = 1; p <= pc; p++) wr(m_param(op, p));
    end
    chk("R4 rqm low", {6'd0, st_rqm, st_busy}, 8'b01);
    if (op == 8'h13) begin m_cfg = m_param(op, 2); m_pre = m_param(op, 3); end
    if (op == 8'h03) begin m_sa = m_param(op, 1); m_sb = m_param(op, 2); end
    if (op == 8'h08 && m_irq) m_irq = 1'b0;
    wait_rqm();
    if (rn == 0) begin
      chk("R9 no result", {5'd0, st_rqm, st_dio, st_busy}, 8'b100);
    end else begin
      chk("R5 result flags", {5'd0, st_rqm, st_dio, st_busy}, 8'b111);
      for (int i = 0; i < rn; i++) begin
        rd(got);
        j = i % DEPTH;
        while (j + DEPTH < rn) j += DEPTH;
        chk(m_tag(op), got, exp_b[j]);
      end
      chk("R6 back to command", {4'd0, st_rqm, st_dio, st_busy, irq}, 8'b1000);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    m_cfg = 0; m_pre = 0; m_sa = 0; m_sb = 0; m_st0 = 0; m_trk = 0; m_irq = 0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    logic [7:0] got;
    do_reset();
    @(negedge clk);
    chk("R1 reset flags", {3'd0, st_rqm, st_dio, st_busy, irq, proto_err}, 8'b10000);

    // R7 R8 R9 R10 R12: sweep every opcode value
    for (int op = 0; op < 256; op++) run_cmd(8'(op));
    run_cmd(8'h13);
    run_cmd(8'h03);
    run_cmd(8'h0E); // R12 wrap of the 10-byte dump in an 8-deep buffer
    chk("R11 no error in sweep", {7'd0, proto_err}, 8'd0);

    // R10: drive event then sense interrupt
    @(negedge clk); ev_pulse = 1'b1; ev_status = 8'h21; ev_track = 8'h4C;
    @(negedge clk); ev_pulse = 1'b0;
    m_irq = 1'b1; m_st0 = 8'h21; m_trk = 8'h4C;
    chk("R10 irq raised", {7'd0, irq}, 8'd1);
    run_cmd(8'h0E); // R12 dump shows latched track, irq cleared at end
    chk("R6 irq dropped after result", {7'd0, irq}, 8'd0);
    m_irq = 1'b0;
    @(negedge clk); ev_pulse = 1'b1; ev_status = 8'h62; ev_track = 8'h07;
    @(negedge clk); ev_pulse = 1'b0;
    m_irq = 1'b1; m_st0 = 8'h62; m_trk = 8'h07;
    run_cmd(8'h08);
    chk("R10 irq cleared", {7'd0, irq}, 8'd0);
    run_cmd(8'h08); // R10 no pending -> 0x80

    // R11: read during command phase
    do_reset();
    rd(got);
    chk("R11 cmd read flags", {4'd0, st_rqm, st_dio, st_busy, proto_err}, 8'b1001);
    run_cmd(8'h18);
    chk("R11 sticky", {7'd0, proto_err}, 8'd1);

    // R11: write during result phase
    do_reset();
    wr(8'h10);
    wait_rqm();
    wr(8'h55);
    chk("R11 res write flags", {4'd0, st_rqm, st_dio, st_busy, proto_err}, 8'b1111);
    rd(got);
    chk("R11 result intact", got, VER);
    chk("R6 after ignored write", {5'd0, st_rqm, st_dio, st_busy}, 8'b100);

    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
    end
  end

endmodule